// File: doc/BRIEF.md
# Scatter-Gather List Walker

This block turns one transfer request into an ordered stream of contiguous (address, length) segments for a DMA engine downstream. A request carries a base address, a total byte count and a flag selecting the mode. With the flag clear, the base address and byte count already describe a single buffer, and the block forwards them as one segment. With the flag set, the base address points at a table of 16-byte descriptors in memory. The block reads these descriptors one at a time, and only when it needs the next one. It cuts each described region against the bytes that are still owed and forwards the pieces.

Descriptor reads go out on a single-outstanding request/response read port. Segments leave on a valid/ready channel. When the walk ends, the block pulses `done`. At that moment it also reports whether the descriptor budget ran out before the byte count was met, and whether any descriptor carried flag bits outside the recognised set. The block does not move any data itself.

Top module: `sg_walker`

## Requirements
- R1: With `req_sg` low, a start produces exactly one segment equal to (`req_addr`, `req_len`); when `req_len` is zero it produces no segment and issues no memory read.
- R2: With `req_sg` high, descriptor k is read from address `req_addr + 16*k`, in increasing k. Each 128-bit response is little-endian: bits [63:0] are the region address, bits [95:64] the region length in bytes and bits [127:96] the flags.
- R3: A descriptor is read only when the residual of the current region is zero. A region of length zero produces no segment, and a segment of length zero is never presented.
- R4: Each segment length is the smaller of the bytes still owed and the region residual. Consecutive pieces of one region are contiguous, and the address, owed count and residual all move on by the piece length when the segment is accepted.
- R5: Once the owed count reaches zero, no further descriptor is read and `done` pulses for exactly one cycle. After reset and after `done`, `busy`, `done`, `seg_valid` and `mem_rd_valid` are low.
- R6: At most `MAX_ELEMS` (default 2048) descriptors are read per walk. The piece taken from the last permitted descriptor is still sent. `truncated` is high with `done` if bytes were still owed when the walk ended, and is low otherwise.
- R7: `flag_warn` goes high when any descriptor of the walk has a flag bit outside `KNOWN_FLAGS` (default: only bits 0 and 1 known). It stays high until the next start, and that descriptor is still used normally.
- R8: A presented segment keeps `seg_valid`, `seg_addr` and `seg_len` unchanged until `seg_ready` accepts it.
- R9: A descriptor read keeps `mem_rd_valid` and `mem_rd_addr` unchanged until `mem_rd_ready`, and no new read is issued before the response to the previous one has arrived.
- R10: `start` and the request inputs are ignored while `busy` is high; the walk in progress continues with the values captured at its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken only while idle) |
| req_sg | input | 1 | 1: `req_addr` points at a descriptor table |
| req_addr | input | ADDR_W | Buffer address or descriptor table address |
| req_len | input | LEN_W | Total bytes to transfer |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| truncated | output | 1 | Descriptor budget ended the walk early |
| flag_warn | output | 1 | A descriptor had unrecognised flag bits |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | ADDR_W | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 128 | Descriptor contents |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |

## Verification
The assertions assume a well-behaved memory. It returns exactly one response for each accepted read, never before that read is accepted, and never while no read is in flight. They also assume that the total byte count fits the length width. The bench memory model answers every accepted read exactly once, after a random delay of one to three cycles, and computes the descriptor contents from the read address. The read-port and segment-port ready signals are randomised every cycle, so that the hold-until-accepted properties are exercised under backpressure.

// File: rtl/sgw_pkg.sv
`timescale 1ns/1ps
package sgw_pkg;

   // Descriptor geometry: one 128-bit little-endian word per table entry.
   localparam int unsigned SGW_ELEM_BYTES = 16;
   localparam int unsigned SGW_ELEM_BITS  = 8 * SGW_ELEM_BYTES;

   // Packed so that the first member lands in the top bits of the word.
   typedef struct packed {
      logic [31:0] flags;
      logic [31:0] len;
      logic [63:0] addr;
   } sgw_elem_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DECIDE,
      ST_FETCH,
      ST_EMIT,
      ST_DONE
   } sgw_state_e;

endpackage

// File: rtl/sgw_chunk.sv
`timescale 1ns/1ps
module sgw_chunk #(
   parameter int unsigned LEN_W = 32
) (
   input  logic [LEN_W-1:0] owed,
   input  logic [LEN_W-1:0] resid,
   output logic [LEN_W-1:0] piece
);

   always_comb begin
      if (owed < resid) piece = owed;
      else              piece = resid;
   end

endmodule

// File: rtl/sgw_elem_limit.sv
`timescale 1ns/1ps
module sgw_elem_limit #(
   parameter int unsigned MAX_ELEMS = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic at_limit
);

   localparam int unsigned CNT_W = $clog2(MAX_ELEMS + 1);

   logic [CNT_W-1:0] cnt_q;

   assign at_limit = (cnt_q == CNT_W'(MAX_ELEMS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (clear)               cnt_q <= '0;
      else if (bump && !at_limit)   cnt_q <= cnt_q + 1'b1;
   end

   // R6: the walker never completes a descriptor read past its budget
   p_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bump |-> !at_limit);

endmodule

// File: rtl/sgw_elem_port.sv
`timescale 1ns/1ps
module sgw_elem_port import sgw_pkg::*; #(
   parameter int unsigned ADDR_W      = 64,
   parameter logic [31:0] KNOWN_FLAGS = 32'h0000_0003,
   parameter bit          CHECK_FLAGS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_ptr,
   input  logic [ADDR_W-1:0]        base_addr,
   input  logic                     fetch_go,
   output logic                     mem_rd_valid,
   input  logic                     mem_rd_ready,
   output logic [ADDR_W-1:0]        mem_rd_addr,
   input  logic                     mem_rsp_valid,
   input  logic [SGW_ELEM_BITS-1:0] mem_rsp_data,
   output logic                     elem_ok,
   output logic [ADDR_W-1:0]        elem_addr,
   output logic [31:0]              elem_len,
   output logic                     elem_bad
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SGW_ELEM_BYTES);

   logic [ADDR_W-1:0] ptr_q;
   logic              req_q;
   logic              wait_q;
   sgw_elem_t         elem;

   assign elem         = sgw_elem_t'(mem_rsp_data);
   assign mem_rd_valid = req_q;
   assign mem_rd_addr  = ptr_q;
   assign elem_ok      = wait_q && mem_rsp_valid;
   assign elem_addr    = elem.addr[ADDR_W-1:0];
   assign elem_len     = elem.len;

   generate
      if (CHECK_FLAGS) begin : g_flag_check
         assign elem_bad = |(elem.flags & ~KNOWN_FLAGS);
      end else begin : g_flag_ignore
         assign elem_bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         req_q  <= 1'b0;
         wait_q <= 1'b0;
      end else begin
         if (load_ptr) ptr_q <= base_addr;
         if (fetch_go) req_q <= 1'b1;
         if (req_q && mem_rd_ready) begin
            req_q  <= 1'b0;
            wait_q <= 1'b1;
         end
         if (elem_ok) begin
            wait_q <= 1'b0;
            ptr_q  <= ptr_q + STEP;
         end
      end
   end

   // R9: request held steady until accepted
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

   // R9: a new fetch is only started with nothing in flight
   p_single_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_go |-> !req_q && !wait_q);

   // R9: environment returns data only for an accepted read
   p_rsp_matched_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> wait_q);

endmodule

// File: rtl/sg_walker.sv
`timescale 1ns/1ps
module sg_walker import sgw_pkg::*; #(
   parameter int unsigned ADDR_W      = 64,
   parameter int unsigned LEN_W       = 32,
   parameter int unsigned MAX_ELEMS   = 2048,
   parameter logic [31:0] KNOWN_FLAGS = 32'h0000_0003,
   parameter bit          CHECK_FLAGS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     req_sg,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [LEN_W-1:0]         req_len,
   output logic                     busy,
   output logic                     done,
   output logic                     truncated,
   output logic                     flag_warn,
   output logic                     mem_rd_valid,
   input  logic                     mem_rd_ready,
   output logic [ADDR_W-1:0]        mem_rd_addr,
   input  logic                     mem_rsp_valid,
   input  logic [SGW_ELEM_BITS-1:0] mem_rsp_data,
   output logic                     seg_valid,
   input  logic                     seg_ready,
   output logic [ADDR_W-1:0]        seg_addr,
   output logic [LEN_W-1:0]         seg_len
);

   // Elaboration-time parameter checks
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("sg_walker: ADDR_W must lie in 8..64");
   end
   if (LEN_W < 32 || LEN_W > 64) begin : g_bad_len_w
      $error("sg_walker: LEN_W must lie in 32..64");
   end
   if (MAX_ELEMS < 1) begin : g_bad_max
      $error("sg_walker: MAX_ELEMS must be at least 1");
   end

   sgw_state_e        state_q;
   logic [LEN_W-1:0]  owed_q;
   logic [LEN_W-1:0]  resid_q;
   logic [ADDR_W-1:0] cur_q;
   logic              trunc_q;
   logic              warn_q;

   logic              take;
   logic              fetch_go;
   logic              at_limit;
   logic              elem_ok;
   logic [ADDR_W-1:0] elem_addr;
   logic [31:0]       elem_len;
   logic              elem_bad;
   logic [LEN_W-1:0]  piece;

   assign take     = (state_q == ST_IDLE) && start;
   assign fetch_go = (state_q == ST_DECIDE) && (owed_q != '0) && !at_limit
                     && (resid_q == '0);

   sgw_chunk #(.LEN_W(LEN_W)) u_chunk (
      .owed  (owed_q),
      .resid (resid_q),
      .piece (piece)
   );

   sgw_elem_limit #(.MAX_ELEMS(MAX_ELEMS)) u_limit (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (take),
      .bump     (elem_ok),
      .at_limit (at_limit)
   );

   sgw_elem_port #(
      .ADDR_W      (ADDR_W),
      .KNOWN_FLAGS (KNOWN_FLAGS),
      .CHECK_FLAGS (CHECK_FLAGS)
   ) u_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_ptr      (take),
      .base_addr     (req_addr),
      .fetch_go      (fetch_go),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_ready  (mem_rd_ready),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .elem_ok       (elem_ok),
      .elem_addr     (elem_addr),
      .elem_len      (elem_len),
      .elem_bad      (elem_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         owed_q  <= '0;
         resid_q <= '0;
         cur_q   <= '0;
         trunc_q <= 1'b0;
         warn_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               owed_q  <= req_len;
               resid_q <= req_sg ? '0 : req_len;
               cur_q   <= req_addr;
               trunc_q <= 1'b0;
               warn_q  <= 1'b0;
               state_q <= ST_DECIDE;
            end
            ST_DECIDE: begin
               if (owed_q == '0)        state_q <= ST_DONE;
               else if (at_limit) begin
                  trunc_q <= 1'b1;
                  state_q <= ST_DONE;
               end
               else if (resid_q != '0)  state_q <= ST_EMIT;
               else                     state_q <= ST_FETCH;
            end
            ST_FETCH: if (elem_ok) begin
               cur_q   <= elem_addr;
               resid_q <= LEN_W'(elem_len);
               warn_q  <= warn_q | elem_bad;
               state_q <= (elem_len != 32'd0) ? ST_EMIT : ST_DECIDE;
            end
            ST_EMIT: if (seg_ready) begin
               cur_q   <= cur_q + ADDR_W'(piece);
               owed_q  <= owed_q - piece;
               resid_q <= resid_q - piece;
               state_q <= ST_DECIDE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign truncated = trunc_q;
   assign flag_warn = warn_q;
   assign seg_valid = (state_q == ST_EMIT);
   assign seg_addr  = cur_q;
   assign seg_len   = piece;

   // R8: offered segment stays put until taken
   p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

   // R3: empty pieces are never offered
   p_seg_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> seg_len != '0);

   // R3: no descriptor read overlaps an offered segment
   p_no_fetch_mid_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> !mem_rd_valid);

   // R5: completion is a single-cycle pulse followed by idle
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R6: truncation is only ever flagged on the completion cycle
   p_trunc_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(truncated) |-> done);

endmodule

// File: tb/test_sg_walker.sv
`timescale 1ns/1ps
module test_sg_walker;

   localparam int unsigned ADDR_W    = 64;
   localparam int unsigned LEN_W     = 32;
   localparam int unsigned MAX_ELEMS = 2048;
   localparam logic [31:0] KNOWN     = 32'h0000_0003;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          req_sg = 1'b0;
   logic [63:0]   req_addr = '0;
   logic [31:0]   req_len = '0;
   logic          busy, done, truncated, flag_warn;
   logic          mem_rd_valid;
   logic          mem_rd_ready = 1'b0;
   logic [63:0]   mem_rd_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [127:0]  mem_rsp_data = '0;
   logic          seg_valid;
   logic          seg_ready = 1'b0;
   logic [63:0]   seg_addr;
   logic [31:0]   seg_len;

   always #4 clk = ~clk;

   sg_walker #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_ELEMS(MAX_ELEMS),
      .KNOWN_FLAGS(KNOWN), .CHECK_FLAGS(1'b1)
   ) i_sg_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .req_sg(req_sg),
      .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
      .truncated(truncated), .flag_warn(flag_warn),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .seg_valid(seg_valid),
      .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len)
   );

   int          checks = 0;
   int          errors = 0;
   int          len_mode = 0;
   logic [31:0] tb_seed = 32'h1234_5678;

   logic [63:0] exp_a [4096];
   logic [31:0] exp_l [4096];
   int          exp_n, exp_fetch;
   bit          exp_trunc, exp_warn;
   logic [63:0] got_a [4096];
   logic [31:0] got_l [4096];
   int          got_n, fetch_n;
   bit          done_seen, got_trunc, got_warn;
   int          cd = 0;
   logic [63:0] rsp_addr = '0;

   function automatic logic [31:0] mix(input logic [63:0] a);
      logic [31:0] h;
      h = (a[31:0] * 32'h9E37_79B1) ^ a[63:32] ^ tb_seed;
      h = h ^ (h >> 15);
      h = h * 32'h85EB_CA6B;
      h = h ^ (h >> 13);
      return h;
   endfunction

   function automatic logic [63:0] f_addr(input logic [63:0] a);
      return {mix(a ^ 64'h55), mix(a)};
   endfunction

   function automatic logic [31:0] f_len(input logic [63:0] a);
      logic [31:0] h;
      h = mix(a + 64'd7);
      if (len_mode == 1) return 32'd1;
      if (len_mode == 2) return 32'd0;
      if (h % 5 == 0) return 32'd0;
      return ((h >> 8) % 40) + 32'd1;
   endfunction

   function automatic logic [31:0] f_flags(input logic [63:0] a);
      logic [31:0] h;
      h = mix(a + 64'd3);
      if (len_mode != 0) return h & 32'h3;
      if (h[20]) return 32'h1 << ((h % 30) + 2);
      return h & 32'h3;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One negedge: observe outputs, run the memory model, set readies.
   task automatic tick();
      @(negedge clk);
      if (done) begin
         done_seen = 1'b1;
         got_trunc = truncated;
         got_warn  = flag_warn;
      end
      mem_rsp_valid = 1'b0;
      if (cd > 0) begin
         cd--;
         if (cd == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = {f_flags(rsp_addr), f_len(rsp_addr), f_addr(rsp_addr)};
         end
      end
      seg_ready    = ($urandom % 4) != 0;
      mem_rd_ready = ($urandom % 3) != 0;
      if (seg_valid && seg_ready) begin
         if (got_n < 4096) begin
            got_a[got_n] = seg_addr;
            got_l[got_n] = seg_len;
         end
         got_n++;
      end
      if (mem_rd_valid && mem_rd_ready) begin
         fetch_n++;
         rsp_addr = mem_rd_addr;
         cd = 1 + ($urandom % 3);
      end
   endtask

   task automatic model(input bit sg, input logic [63:0] a0, input logic [31:0] len);
      logic [63:0] ptr, cur;
      logic [31:0] owed, resid, ch;
      int cnt;
      exp_n = 0; exp_fetch = 0; exp_trunc = 0; exp_warn = 0;
      owed = len;
      if (!sg) begin
         if (len != 0) begin
            exp_a[0] = a0; exp_l[0] = len; exp_n = 1;
         end
         return;
      end
      ptr = a0; resid = 0; cur = 0; cnt = 0;
      while (owed != 0 && cnt < MAX_ELEMS) begin
         while (resid == 0 && cnt < MAX_ELEMS) begin
            cur   = f_addr(ptr);
            resid = f_len(ptr);
            if ((f_flags(ptr) & ~KNOWN) != 0) exp_warn = 1;
            cnt++;
            ptr = ptr + 64'd16;
         end
         ch = (owed < resid) ? owed : resid;
         if (ch != 0) begin
            exp_a[exp_n] = cur; exp_l[exp_n] = ch; exp_n++;
         end
         cur   = cur + 64'(ch);
         owed  = owed - ch;
         resid = resid - ch;
      end
      exp_fetch = cnt;
      exp_trunc = (owed != 0);
   endtask

   task automatic run(input bit sg, input logic [63:0] a0, input logic [31:0] len,
                      input bit poke, input string tag);
      int wd;
      int lim;
      model(sg, a0, len);
      got_n = 0; fetch_n = 0; done_seen = 0;
      tick();
      req_sg = sg; req_addr = a0; req_len = len; start = 1'b1;
      tick();
      start = 1'b0; req_sg = ~sg; req_addr = ~a0; req_len = len + 32'd5;
      wd = 0;
      while (!done_seen && wd < 60000) begin
         tick();
         wd++;
         start = poke && (wd == 3) && !done_seen;
      end
      start = 1'b0;
      check(done_seen, "R5", "walk completion (watchdog)", 64'(wd), 64'd0);
      check(got_n == exp_n, tag, "segment count", 64'(got_n), 64'(exp_n));
      lim = (got_n < exp_n) ? got_n : exp_n;
      for (int i = 0; i < lim; i++) begin
         check(got_a[i] == exp_a[i], tag, "segment address", got_a[i], exp_a[i]);
         check(got_l[i] == exp_l[i], tag, "segment length", 64'(got_l[i]), 64'(exp_l[i]));
      end
      check(fetch_n == exp_fetch, "R2", "descriptor reads", 64'(fetch_n), 64'(exp_fetch));
      check(got_trunc == exp_trunc, "R6", "truncated", 64'(got_trunc), 64'(exp_trunc));
      check(got_warn == exp_warn, "R7", "flag_warn", 64'(got_warn), 64'(exp_warn));
      tick();
      check(!busy && !seg_valid && !mem_rd_valid, "R5", "idle after done",
            {61'd0, busy, seg_valid, mem_rd_valid}, 64'd0);
   endtask

   initial begin
      void'($urandom(32'd20240));
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check(!busy && !done && !seg_valid && !mem_rd_valid, "R5", "reset state",
            {60'd0, busy, done, seg_valid, mem_rd_valid}, 64'd0);
      check(!truncated && !flag_warn, "R5", "reset flags",
            {62'd0, truncated, flag_warn}, 64'd0);

      // R1: direct buffer, one segment
      run(1'b0, 64'h1000_0000_0000_0040, 32'd100, 1'b0, "R1");
      // R1: direct buffer of zero bytes
      run(1'b0, 64'h2000, 32'd0, 1'b0, "R1");
      // R5: table walk with nothing owed reads nothing
      run(1'b1, 64'h3000, 32'd0, 1'b0, "R5");
      // R3/R4: table with zero-length regions and partial last region
      tb_seed = 32'hA5A5_0001; len_mode = 0;
      run(1'b1, 64'h0000_4000_0000_0000, 32'd300, 1'b0, "R4");
      tb_seed = 32'hA5A5_0002;
      run(1'b1, 64'h0000_0000_0000_0008, 32'd37, 1'b0, "R3");
      // R6: budget exactly used up, no truncation
      len_mode = 1; tb_seed = 32'h0000_0777;
      run(1'b1, 64'h8000, 32'd2048, 1'b0, "R6");
      // R6: budget exhausted with bytes owed
      run(1'b1, 64'h9000, 32'd5000, 1'b0, "R6");
      // R3: every region empty, nothing offered, walk truncated
      len_mode = 2;
      run(1'b1, 64'hA000, 32'd10, 1'b0, "R3");
      // R10: start pulsed mid-walk is ignored
      len_mode = 0; tb_seed = 32'h0BAD_F00D;
      run(1'b1, 64'h0000_0000_00C0_0000, 32'd400, 1'b1, "R10");
      // Constrained random mix
      for (int k = 0; k < 30; k++) begin
         bit          sg;
         logic [63:0] a;
         logic [31:0] l;
         tb_seed = $urandom;
         sg = ($urandom % 4) != 0;
         a  = {$urandom, $urandom};
         l  = ($urandom % 8 == 0) ? 32'd0 : ($urandom % 600);
         run(sg, a, l, ($urandom % 5) == 0, sg ? "R4" : "R1");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule